// File: doc/BRIEF.md
# Converter serial-master output sequencer

This block is the digital output side of a 16-bit successive-approximation converter that drives its own serial link as bus master. A start pulse begins a conversion of a fixed number of system clocks and raises `busy` while it runs. A parallel word input stands in for the analog core. At the end of the conversion that word is captured into a holding register. The block then sends a result over three lines: a serial clock derived from the system clock, a frame strobe, and a data line.

A mode input picks when the result is sent. In read-after mode the freshly captured word is shifted out once the conversion ends, and `busy` stays high until the last bit has gone. In read-during mode the word captured by the previous conversion is shifted out while the new conversion runs, and `busy` ends with the conversion. Serial traffic needs two conditions: the internal-clock select must be low and the read qualifier must be high. The clock and frame strobe each have their own polarity-inversion input.

Top module: `sar_serial_master`

## Requirements
- R1: After reset `busy` is 0, `sdo` is 0, `sck` equals `inv_sck` and `frm` equals `inv_frm`.
- R2: A `conv_start` sampled high while `busy` is 0 raises `busy` from the next cycle. Without a read-after frame, `busy` stays high for exactly CONV_CYC cycles.
- R3: With `rd_during`=0 and serial traffic enabled, the frame begins in the cycle after the conversion ends. `busy` then stays high until the frame closes, for CONV_CYC + DW*2*SCK_DIV cycles in total.
- R4: With `rd_during`=1 and serial traffic enabled, the frame begins in the first `busy` cycle and carries the word captured by the previous conversion. This word is zero after reset.
- R5: Bits leave most significant first, one per serial clock period. Each bit is valid when the uninverted serial clock rises. `sdo` changes only on the falling half and is 0 outside a frame.
- R6: The frame is active for exactly DW serial clock periods (DW*2*SCK_DIV system cycles) and contains exactly DW rising edges of the uninverted serial clock.
- R7: `sck` is the internal clock XOR `inv_sck` and `frm` is the internal frame XOR `inv_frm`. The internal clock rests low and the internal frame is active high.
- R8: With `ext_clk_sel`=1, `sck` and `frm` stay at their rest levels and no frame is sent. Conversion timing and result capture are unchanged.
- R9: With `rd_qual`=0, no frame is sent. In read-after mode `busy` then ends with the conversion.
- R10: A `conv_start` that arrives while `busy` is high is ignored, including in the final `busy` cycle. It does not alter `busy` timing or the captured result.
- R11: Every conversion captures `core_word` into the holding register at its end, whether or not a frame was sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start | input | 1 | Conversion start request |
| ext_clk_sel | input | 1 | 1 = serial clock supplied externally (block stays quiet) |
| rd_during | input | 1 | 1 = send previous word during conversion, 0 = send new word after |
| rd_qual | input | 1 | Read qualifier; serial traffic only while high |
| inv_sck | input | 1 | Invert serial clock polarity |
| inv_frm | input | 1 | Invert frame strobe polarity |
| core_word | input | DW | Conversion result from the core model |
| busy | output | 1 | Conversion (and read-after frame) in progress |
| sck | output | 1 | Serial clock |
| frm | output | 1 | Frame strobe, marks valid data |
| sdo | output | 1 | Serial data, MSB first |

## Verification
Two events can fall on the same system edge. The first pair is the end of a conversion, when the holding register captures a word, and the load of that same word into the shifter in read-after mode. The second pair is the final `busy` cycle and a fresh start request, which must be ignored. The bench provokes the second pair by raising `conv_start` exactly in the last cycle where `busy` reads high. It then checks that `busy` drops on time and stays low. The first pair is judged by comparing the shifted bits with the word presented on the capture cycle, and by confirming that the next read-during frame repeats that same word.

// File: rtl/sar_ser_pkg.sv
package sar_ser_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CONV  = 2'd1,
      ST_DRAIN = 2'd2
   } seq_st_t;
endpackage

// File: rtl/sar_conv_timer.sv
module sar_conv_timer #(
   parameter int CONV_CYC = 80
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   output logic running,
   output logic done
);
   localparam int CW = $clog2(CONV_CYC + 1);
   localparam logic [CW-1:0] LAST = CW'(CONV_CYC - 1);

   logic [CW-1:0] cnt;

   generate
      if (CONV_CYC < 2) begin : g_bad_len
         $error("sar_conv_timer: CONV_CYC must be at least 2");
      end
   endgenerate

   assign done = running && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         cnt     <= '0;
      end else if (launch) begin
         running <= 1'b1;
         cnt     <= '0;
      end else if (running) begin
         if (cnt == LAST) begin
            running <= 1'b0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // conversion window closes right after its final count
   assert_conv_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done && !launch |=> !running);

   // the counter never runs past its final value
   assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> cnt <= LAST);
endmodule

// File: rtl/sar_ser_shifter.sv
module sar_ser_shifter #(
   parameter int DW      = 16,
   parameter int SCK_DIV = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] word,
   output logic          act,
   output logic          sck_raw,
   output logic          sdo,
   output logic          fin
);
   localparam int BCW = (DW > 1) ? $clog2(DW) : 1;
   localparam int DCW = (SCK_DIV > 1) ? $clog2(SCK_DIV) : 1;
   localparam logic [BCW-1:0] LAST_BIT = BCW'(DW - 1);

   logic [DW-1:0]  shreg;
   logic [BCW-1:0] bit_cnt;
   logic           tick;
   logic           fall;

   generate
      if (SCK_DIV < 1) begin : g_bad_div
         $error("sar_ser_shifter: SCK_DIV must be at least 1");
      end
      if (SCK_DIV == 1) begin : g_nodiv
         assign tick = act;
      end else begin : g_div
         logic [DCW-1:0] div_cnt;
         assign tick = act && (div_cnt == DCW'(SCK_DIV - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_cnt <= '0;
            end else if (!act || tick || load) begin
               div_cnt <= '0;
            end else begin
               div_cnt <= div_cnt + 1'b1;
            end
         end
      end
   endgenerate

   assign fall = tick && sck_raw;
   assign fin  = fall && (bit_cnt == LAST_BIT);
   assign sdo  = act && shreg[DW-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act     <= 1'b0;
         sck_raw <= 1'b0;
         shreg   <= '0;
         bit_cnt <= '0;
      end else if (load) begin
         act     <= 1'b1;
         sck_raw <= 1'b0;
         shreg   <= word;
         bit_cnt <= '0;
      end else if (tick) begin
         sck_raw <= ~sck_raw;
         if (fall) begin
            if (bit_cnt == LAST_BIT) begin
               act <= 1'b0;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
               shreg   <= {shreg[DW-2:0], 1'b0};
            end
         end
      end
   end

   // clock rests low whenever no frame is running
   assert_sck_rest_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !act |-> !sck_raw);

   // data only moves while the clock is in its high half (falling edge next)
   assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      act && $past(act) && !$past(load) && !$past(sck_raw) |-> $stable(shreg));

   // bit index stays inside the word
   assert_bit_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      act |-> bit_cnt <= LAST_BIT);
endmodule

// File: rtl/sar_serial_master.sv
module sar_serial_master
   import sar_ser_pkg::*;
#(
   parameter int DW       = 16,
   parameter int CONV_CYC = 80,
   parameter int SCK_DIV  = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          conv_start,
   input  logic          ext_clk_sel,
   input  logic          rd_during,
   input  logic          rd_qual,
   input  logic          inv_sck,
   input  logic          inv_frm,
   input  logic [DW-1:0] core_word,
   output logic          busy,
   output logic          sck,
   output logic          frm,
   output logic          sdo
);
   localparam int FRAME_CYC = DW * 2 * SCK_DIV;

   generate
      if (DW < 2) begin : g_bad_dw
         $error("sar_serial_master: DW must be at least 2");
      end
      if (FRAME_CYC > CONV_CYC) begin : g_bad_fit
         $error("sar_serial_master: read-during frame must fit inside CONV_CYC");
      end
   endgenerate

   seq_st_t       st;
   logic          mode_q;
   logic [DW-1:0] held;
   logic          accept;
   logic          ser_ok;
   logic          conv_run;
   logic          conv_done;
   logic          sh_load;
   logic [DW-1:0] sh_word;
   logic          sh_act;
   logic          sh_sck;
   logic          sh_sdo;
   logic          sh_fin;

   assign accept  = (st == ST_IDLE) && conv_start;
   assign ser_ok  = rd_qual && !ext_clk_sel;
   assign sh_load = (accept && rd_during && ser_ok)
                 || (conv_done && !mode_q && ser_ok);
   assign sh_word = accept ? held : core_word;

   sar_conv_timer #(.CONV_CYC(CONV_CYC)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .launch  (accept),
      .running (conv_run),
      .done    (conv_done)
   );

   sar_ser_shifter #(.DW(DW), .SCK_DIV(SCK_DIV)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (sh_load),
      .word    (sh_word),
      .act     (sh_act),
      .sck_raw (sh_sck),
      .sdo     (sh_sdo),
      .fin     (sh_fin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         mode_q <= 1'b0;
         held   <= '0;
      end else begin
         if (conv_done) begin
            held <= core_word;
         end
         case (st)
            ST_IDLE: begin
               if (accept) begin
                  st     <= ST_CONV;
                  mode_q <= rd_during;
               end
            end
            ST_CONV: begin
               if (conv_done) begin
                  st <= (!mode_q && ser_ok) ? ST_DRAIN : ST_IDLE;
               end
            end
            ST_DRAIN: begin
               if (sh_fin) begin
                  st <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy = (st != ST_IDLE);
   assign sck  = sh_sck ^ inv_sck;
   assign frm  = sh_act ^ inv_frm;
   assign sdo  = sh_sdo;

   // a start seen while idle raises busy on the next cycle
   assert_busy_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && conv_start |=> busy);

   // serial frames only exist inside a busy period
   assert_frame_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sh_act |-> busy);

   // the drain phase of read-after mode always has a frame running
   assert_drain_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
      st == ST_DRAIN |-> sh_act);

   // conversion timer runs exactly while in the conversion phase
   assert_timer_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
      conv_run |-> st == ST_CONV);

   // the holding register takes the core word at conversion end
   assert_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |=> held == $past(core_word));
endmodule

// File: tb/sim_sar_serial_master.sv
module sim_sar_serial_master;
   localparam int DW        = 16;
   localparam int CONV_CYC  = 80;
   localparam int SCK_DIV   = 2;
   localparam int FRAME_CYC = DW * 2 * SCK_DIV;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          conv_start = 1'b0;
   logic          ext_clk_sel = 1'b0;
   logic          rd_during = 1'b0;
   logic          rd_qual = 1'b1;
   logic          inv_sck = 1'b0;
   logic          inv_frm = 1'b0;
   logic [DW-1:0] core_word = '0;
   logic          busy, sck, frm, sdo;

   int n_chk = 0;
   int n_bad = 0;
   logic [DW-1:0] prev_word = '0;

   always #10 clk = ~clk;

   sar_serial_master #(.DW(DW), .CONV_CYC(CONV_CYC), .SCK_DIV(SCK_DIV)) u0 (
      .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .ext_clk_sel(ext_clk_sel),
      .rd_during(rd_during), .rd_qual(rd_qual), .inv_sck(inv_sck), .inv_frm(inv_frm),
      .core_word(core_word), .busy(busy), .sck(sck), .frm(frm), .sdo(sdo)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   function automatic int exp_busy_len(input bit mode, input bit ser);
      return (!mode && ser) ? CONV_CYC + FRAME_CYC : CONV_CYC;
   endfunction

   function automatic int exp_first_frame(input bit mode);
      return mode ? 1 : CONV_CYC + 1;
   endfunction

   // glitch: 0 none, 1 mid-conversion, 2 final busy cycle
   task automatic run_conv(input bit mode, input logic [DW-1:0] word, input bit en,
                           input bit ext, input bit is, input bit ifr, input int glitch);
      bit ser;
      int blen, busy_cnt, busy_last, frm_cnt, frm_first, rises, rest_bad, sdo_bad;
      int gcyc;
      bit ls_prev;
      logic [DW-1:0] cap;
      logic [DW-1:0] exp_word;
      string tb;
      ser = en && !ext;
      blen = exp_busy_len(mode, ser);
      exp_word = mode ? prev_word : word;
      gcyc = (glitch == 1) ? CONV_CYC / 2 : blen;
      @(negedge clk);
      rd_during = mode; rd_qual = en; ext_clk_sel = ext; inv_sck = is; inv_frm = ifr;
      @(negedge clk);
      @(negedge clk);
      chk("R7 rest sck", int'(sck), int'(is));
      chk("R7 rest frm", int'(frm), int'(ifr));
      core_word = word;
      conv_start = 1'b1;
      busy_cnt = 0; busy_last = 0; frm_cnt = 0; frm_first = 0; rises = 0;
      rest_bad = 0; sdo_bad = 0; ls_prev = 1'b0; cap = '0;
      for (int i = 1; i <= CONV_CYC + FRAME_CYC + 6; i++) begin
         @(negedge clk);
         conv_start = 1'b0;
         if (busy) begin busy_cnt++; busy_last = i; end
         if ((frm ^ ifr) == 1'b1) begin
            frm_cnt++;
            if (frm_first == 0) frm_first = i;
            if ((sck ^ is) && !ls_prev) begin
               cap = {cap[DW-2:0], sdo};
               rises++;
            end
         end else if (sdo !== 1'b0) begin
            sdo_bad++;
         end
         if (!ser && ((sck !== is) || (frm !== ifr))) rest_bad++;
         ls_prev = sck ^ is;
         if (glitch != 0 && i == gcyc) conv_start = 1'b1;
      end
      if (glitch != 0) tb = "R10";
      else if (!mode && ser) tb = "R3";
      else if (ext) tb = "R8";
      else if (!en) tb = "R9";
      else tb = "R2";
      chk({tb, " busy length"}, busy_cnt, blen);
      chk({tb, " busy contiguous"}, busy_last, blen);
      chk("R5 sdo low outside frame", sdo_bad, 0);
      if (ser) begin
         chk(mode ? "R4 frame start" : "R3 frame start", frm_first, exp_first_frame(mode));
         chk("R6 frame cycles", frm_cnt, FRAME_CYC);
         chk("R6 clock periods", rises, DW);
         chk(mode ? "R4 R11 previous word" : "R5 new word msb first", int'(cap), int'(exp_word));
      end else begin
         chk(ext ? "R8 no frame" : "R9 no frame", frm_cnt, 0);
         chk(ext ? "R8 lines at rest" : "R9 lines at rest", rest_bad, 0);
      end
      prev_word = word;
   endtask

   initial begin
      #(20 * 100000);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      chk("R1 busy", int'(busy), 0);
      chk("R1 sck", int'(sck), 0);
      chk("R1 frm", int'(frm), 0);
      chk("R1 sdo", int'(sdo), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy after release", int'(busy), 0);
      // first read-during frame after reset carries zero
      run_conv(1'b1, 16'h1234, 1'b1, 1'b0, 1'b0, 1'b0, 0);
      run_conv(1'b0, 16'hA5C3, 1'b1, 1'b0, 1'b0, 1'b0, 0);
      run_conv(1'b1, 16'h8001, 1'b1, 1'b0, 1'b1, 1'b1, 0);
      run_conv(1'b0, 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b0, 0);
      run_conv(1'b0, 16'h0F0F, 1'b1, 1'b1, 1'b0, 1'b1, 0);
      run_conv(1'b1, 16'h7777, 1'b1, 1'b0, 1'b0, 1'b0, 0);
      run_conv(1'b0, 16'h3C3C, 1'b0, 1'b0, 1'b0, 0, 0);
      run_conv(1'b1, 16'h0001, 1'b1, 1'b0, 1'b0, 1'b0, 0);
      run_conv(1'b0, 16'hBEEF, 1'b1, 1'b0, 1'b0, 1'b0, 1);
      run_conv(1'b0, 16'h5555, 1'b1, 1'b0, 1'b0, 1'b0, 2);
      run_conv(1'b1, 16'hCAFE, 1'b1, 1'b0, 1'b1, 1'b1, 2);
      for (int k = 0; k < 24; k++) begin
         run_conv(1'($urandom), 16'($urandom), ($urandom % 4) != 0, ($urandom % 5) == 0,
                  1'($urandom), 1'($urandom), int'($urandom % 3));
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule